// File: doc/BRIEF.md
# Next-Frame Reply Safety SPI Slave

This block is the slave end of a 32-bit SPI link. The reply to a command is carried in the frame that follows the command. The bus runs in mode 0 (clock idles low, data sampled on the rising edge), and bits are sent most significant first. The block samples the SPI pins in its own system clock domain through two-flop synchronizers. It shifts in each command and checks the command's 3-bit CRC. It then decodes the command's address field and decides what the next frame should return.

A command can be for one of up to four slaves sharing one chip select. A command that fails the CRC, names another slave, or names a target this slave does not know is answered with silence: during the next frame the MISO output enable stays low. A sensor read captures a sensor sample and a 2-bit status code from the parallel inputs when the command frame ends. An identity read returns a fixed device code. The reply word carries its own CRC, computed the same way as the command CRC.

Top module: `nxf_spi_slave`

## Requirements
- R1: A frame is 32 bits, MSB first. MOSI is taken on each synchronized rising SCK edge. The first reply bit is presented after CS falls and before the first rising edge. Each following bit is presented after a falling edge.
- R2: `spi_miso_oe` is low whenever `spi_cs_n` is high, including the cycle right after CS rises. `spi_miso` is 0 whenever `spi_miso_oe` is low.
- R3: The command CRC check works as follows. A 3-bit register starts at 101. Bits 31:3 are shifted through it, MSB first, followed by three zeros, with feedback polynomial x^3+x+1. The result must equal bits 2:0. A command that fails this check gets no drive in the next frame.
- R4: Command bits 31:30 must equal `cfg_slave_addr`. Otherwise the next frame is not driven.
- R5: A valid command with bit 29 = 1 is a sensor read. The next reply has these fields: bit 31 = 1; bits 30:29 = `cfg_slave_addr`; bits 28:21 = command bits 29:22; bit 20 = status[1]; bits 19:4 = sample; bit 3 = status[0]. All four status codes pass through unchanged. Sample and status are captured at the end of the command frame.
- R6: The SENSOR_W-bit two's-complement sample sits MSB-aligned in reply bits 19:(20-SENSOR_W), and the unused low bits are zero.
- R7: A valid command with bit 29 = 0 and bits 28:22 = ID_REG is an identity read. The next reply has bit 31 = 0, the same address fields as R5, bit 20 = 0, bits 19:4 = DEV_ID and bit 3 = 0.
- R8: A command with a good CRC and a matching address, but with bit 29 = 0 and bits 28:22 other than ID_REG, gets no drive in the next frame.
- R9: Reply bits 2:0 are the CRC of reply bits 31:3, computed as in R3.
- R10: After reset, the first frame is driven with a non-sensor reply. Its fields are: bits 28:21 = 0, data = 0, bit 20 = 0 and bit 3 = 1 (status 01).
- R11: A frame in which CS rises after any number of rising edges other than 32 is discarded. The following frame repeats the reply that the discarded frame carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Command data from master |
| spi_miso | output | 1 | Reply data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad |
| cfg_slave_addr | input | 2 | Programmed slave address |
| sns_data | input | SENSOR_W | Sensor sample, two's complement |
| sns_status | input | 2 | Sensor status code |

## Verification
The reply register loads about four system clocks after CS falls: two synchronizer stages plus one edge register. Each shift follows a falling SCK edge by the same amount. The bench holds every SCK phase for eight clocks, so it reads MISO and the enable on the clock before each rising edge, when the bit has long settled. A command's decoded reply becomes pending about five clocks after CS rises. The bench leaves at least twelve idle clocks between frames, then compares the whole next frame against a reply it builds from the requirements. The enable is also read one clock after CS rises. At that point the synchronized chip select is still low, which isolates the direct gating by the CS pin.

// File: rtl/nxf_spi_pkg.sv
package nxf_spi_pkg;

  localparam int FRAME_LEN = 32;
  localparam int CRC_LEN   = 3;
  localparam int BODY_LEN  = FRAME_LEN - CRC_LEN;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam int DATA_W    = 16;

  localparam logic [CRC_LEN-1:0] CRC_SEED = 3'b101;
  localparam logic [CRC_LEN-1:0] CRC_TAPS = 3'b011;

  // Reply waiting for the next frame
  typedef struct packed {
    logic              drive;
    logic              sensor;
    logic [7:0]        sa_lo;
    logic [1:0]        stat;
    logic [DATA_W-1:0] data;
  } resp_t;

  // Register form: body then three zero bits shifted through x^3+x+1
  function automatic logic [CRC_LEN-1:0] crc3_of(input logic [BODY_LEN-1:0] body);
    logic [CRC_LEN-1:0] r;
    logic               fb;
    r = CRC_SEED;
    for (int i = BODY_LEN - 1; i >= 0; i--) begin
      fb = r[CRC_LEN-1];
      r  = {r[CRC_LEN-2:0], body[i]};
      if (fb) r = r ^ CRC_TAPS;
    end
    for (int i = 0; i < CRC_LEN; i++) begin
      fb = r[CRC_LEN-1];
      r  = {r[CRC_LEN-2:0], 1'b0};
      if (fb) r = r ^ CRC_TAPS;
    end
    return r;
  endfunction

  function automatic logic [FRAME_LEN-1:0] pack_reply(input resp_t p, input logic [1:0] addr);
    logic [BODY_LEN-1:0] body;
    body = {p.sensor, addr, p.sa_lo, p.stat[1], p.data, p.stat[0]};
    return {body, crc3_of(body)};
  endfunction

endpackage

// File: rtl/nxf_sync.sv
module nxf_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/nxf_rx_frame.sv
module nxf_rx_frame
  import nxf_spi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_active,
  input  logic                 sck_rise,
  input  logic                 mosi_bit,
  output logic                 frame_start,
  output logic                 frame_done,
  output logic                 frame_abort,
  output logic [FRAME_LEN-1:0] rx_word
);

  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN + 1);

  logic             cs_d;
  logic             cs_end;
  logic [CNT_W-1:0] bit_cnt;

  assign frame_start = cs_active & ~cs_d;
  assign cs_end      = ~cs_active & cs_d;
  assign frame_done  = cs_end & (bit_cnt == CNT_DONE);
  assign frame_abort = cs_end & (bit_cnt != CNT_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d    <= 1'b0;
      bit_cnt <= '0;
      rx_word <= '0;
    end else begin
      cs_d <= cs_active;
      if (frame_start) begin
        bit_cnt <= '0;
      end else if (cs_active && sck_rise) begin
        rx_word <= {rx_word[FRAME_LEN-2:0], mosi_bit};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R11: frame boundary events never coincide
  p_frame_events_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, frame_done, frame_abort}));

endmodule

// File: rtl/nxf_decode.sv
module nxf_decode
  import nxf_spi_pkg::*;
#(
  parameter int          SENSOR_W = 12,
  parameter logic [6:0]  ID_REG   = 7'h2A,
  parameter logic [15:0] DEV_ID   = 16'h5AC3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  logic                 frame_abort,
  input  logic [FRAME_LEN-1:0] rx_word,
  input  logic [1:0]           slave_addr,
  input  logic [SENSOR_W-1:0]  sns_data,
  input  logic [1:0]           sns_status,
  output resp_t                pend
);

  localparam int    PAD        = DATA_W - SENSOR_W;
  localparam resp_t RESET_RESP = '{drive: 1'b1, sensor: 1'b0, sa_lo: 8'h00,
                                   stat: 2'b01, data: '0};

  logic [9:0]        ta;
  logic              crc_ok;
  logic              addr_ok;
  logic              is_sensor;
  logic              id_hit;
  logic              accept;
  logic [DATA_W-1:0] sample_al;

  assign ta        = rx_word[FRAME_LEN-1 -: 10];
  assign crc_ok    = (crc3_of(rx_word[FRAME_LEN-1:CRC_LEN]) == rx_word[CRC_LEN-1:0]);
  assign addr_ok   = (ta[9:8] == slave_addr);
  assign is_sensor = ta[7];
  assign id_hit    = ~ta[7] & (ta[6:0] == ID_REG);
  assign accept    = crc_ok & addr_ok & (is_sensor | id_hit);

  generate
    if (PAD == 0) begin : g_full
      assign sample_al = sns_data;
    end else begin : g_pad
      assign sample_al = {sns_data, {PAD{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= RESET_RESP;
    end else if (frame_done) begin
      pend.drive  <= accept;
      pend.sensor <= is_sensor;
      pend.sa_lo  <= ta[7:0];
      pend.stat   <= is_sensor ? sns_status : 2'b00;
      pend.data   <= is_sensor ? sample_al : DEV_ID;
    end
  end

  // R3: a corrupted command silences the next reply
  p_bad_crc_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !crc_ok) |=> !pend.drive);

  // R4: a command for another slave silences the next reply
  p_foreign_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !addr_ok) |=> !pend.drive);

  // R8: an unknown non-sensor target silences the next reply
  p_unknown_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !is_sensor && !id_hit) |=> !pend.drive);

  // R11: a discarded frame leaves the pending reply untouched
  p_abort_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> $stable(pend));

endmodule

// File: rtl/nxf_tx_frame.sv
module nxf_tx_frame
  import nxf_spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       cs_active,
  input  logic       sck_fall,
  input  logic       cs_n_pin,
  input  resp_t      pend,
  input  logic [1:0] slave_addr,
  output logic       miso,
  output logic       miso_oe
);

  logic [FRAME_LEN-1:0] tx_sh;
  logic                 tx_drive;
  logic                 tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      tx_drive  <= 1'b0;
      tx_active <= 1'b0;
    end else if (frame_start) begin
      tx_sh     <= pack_reply(pend, slave_addr);
      tx_drive  <= pend.drive;
      tx_active <= 1'b1;
    end else if (!cs_active) begin
      tx_active <= 1'b0;
    end else if (sck_fall && tx_active) begin
      tx_sh <= {tx_sh[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign miso_oe = tx_active & tx_drive & ~cs_n_pin;
  assign miso    = miso_oe & tx_sh[FRAME_LEN-1];

  // R1: each falling edge moves the next lower bit to the pin
  p_msb_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && cs_active && sck_fall && !frame_start)
      |=> (tx_sh[FRAME_LEN-1] == $past(tx_sh[FRAME_LEN-2])));

  // R2: once the chip select is seen released, the pad stays off
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_active && !frame_start) |=> !miso_oe);

endmodule

// File: rtl/nxf_spi_slave.sv
module nxf_spi_slave
  import nxf_spi_pkg::*;
#(
  parameter int          SENSOR_W = 12,
  parameter int          SYNC_STG = 2,
  parameter logic [6:0]  ID_REG   = 7'h2A,
  parameter logic [15:0] DEV_ID   = 16'h5AC3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  input  logic [1:0]          cfg_slave_addr,
  input  logic [SENSOR_W-1:0] sns_data,
  input  logic [1:0]          sns_status
);

  logic                 s_cs_n;
  logic                 s_sck;
  logic                 s_mosi;
  logic                 sck_d;
  logic                 cs_active;
  logic                 sck_rise;
  logic                 sck_fall;
  logic                 frame_start;
  logic                 frame_done;
  logic                 frame_abort;
  logic [FRAME_LEN-1:0] rx_word;
  resp_t                pend;

  nxf_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sck, spi_mosi}),
    .q     ({s_cs_n, s_sck, s_mosi})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= s_sck;
  end

  assign cs_active = ~s_cs_n;
  assign sck_rise  = s_sck & ~sck_d;
  assign sck_fall  = ~s_sck & sck_d;

  nxf_rx_frame u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_active   (cs_active),
    .sck_rise    (sck_rise),
    .mosi_bit    (s_mosi),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .rx_word     (rx_word)
  );

  nxf_decode #(.SENSOR_W(SENSOR_W), .ID_REG(ID_REG), .DEV_ID(DEV_ID)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .rx_word     (rx_word),
    .slave_addr  (cfg_slave_addr),
    .sns_data    (sns_data),
    .sns_status  (sns_status),
    .pend        (pend)
  );

  nxf_tx_frame u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cs_active   (cs_active),
    .sck_fall    (sck_fall),
    .cs_n_pin    (spi_cs_n),
    .pend        (pend),
    .slave_addr  (cfg_slave_addr),
    .miso        (spi_miso),
    .miso_oe     (spi_miso_oe)
  );

  // R2: undriven pad carries a quiet zero
  p_quiet_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);

endmodule

// File: tb/nxf_spi_slave_tb.sv
module nxf_spi_slave_tb;

  localparam int          SW     = 12;
  localparam logic [6:0]  ID_REG = 7'h2A;
  localparam logic [15:0] DEV_ID = 16'h5AC3;
  localparam int          NVEC   = 10;

  // {addr[2], status[2], sample[12], target[10], corrupt[1]}
  localparam logic [26:0] VEC [NVEC] = '{
    {2'd0, 2'b00, 12'h7FF, 10'h081, 1'b0},
    {2'd0, 2'b11, 12'h800, 10'h085, 1'b0},
    {2'd0, 2'b00, 12'h000, 10'h02A, 1'b0},
    {2'd0, 2'b00, 12'h123, 10'h180, 1'b0},
    {2'd0, 2'b00, 12'h456, 10'h0C0, 1'b1},
    {2'd0, 2'b00, 12'h789, 10'h005, 1'b0},
    {2'd2, 2'b10, 12'hABC, 10'h2FF, 1'b0},
    {2'd2, 2'b01, 12'h001, 10'h280, 1'b0},
    {2'd3, 2'b00, 12'hFFF, 10'h32A, 1'b0},
    {2'd3, 2'b00, 12'h123, 10'h3D5, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck = 1'b0;
  logic          cs_n = 1'b1;
  logic          mosi = 1'b0;
  logic          miso;
  logic          miso_oe;
  logic [1:0]    cfg_addr = 2'd0;
  logic [SW-1:0] sns_data = '0;
  logic [1:0]    sns_stat = 2'b00;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the pending reply
  logic        e_drive;
  logic        e_sens;
  logic [7:0]  e_sa;
  logic [1:0]  e_stat;
  logic [15:0] e_data;
  string       e_tag;

  always #5 clk = ~clk;

  nxf_spi_slave u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_sck        (sck),
    .spi_cs_n       (cs_n),
    .spi_mosi       (mosi),
    .spi_miso       (miso),
    .spi_miso_oe    (miso_oe),
    .cfg_slave_addr (cfg_addr),
    .sns_data       (sns_data),
    .sns_status     (sns_stat)
  );

  // polynomial long division of {seed, body, 000} by 1011
  function automatic logic [2:0] ref_crc(input logic [28:0] body);
    logic [34:0] v;
    v = {3'b101, body, 3'b000};
    for (int i = 34; i >= 3; i--)
      if (v[i]) v[i -: 4] = v[i -: 4] ^ 4'b1011;
    return v[2:0];
  endfunction

  function automatic logic [31:0] make_cmd(input logic [9:0] ta, input logic bad);
    logic [28:0] body;
    logic [2:0]  c;
    body = {ta, 19'h2B5C1};
    c = ref_crc(body);
    if (bad) c[0] = ~c[0];
    return {body, c};
  endfunction

  function automatic logic [31:0] exp_word(input logic [1:0] addr);
    logic [28:0] body;
    body = {e_sens, addr, e_sa, e_stat[1], e_data, e_stat[0]};
    return {body, ref_crc(body)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] mo, input int nbits, output logic [31:0] mi,
                      output logic oe_all, output logic oe_any, output logic oe_after);
    mi = '0; oe_all = 1'b1; oe_any = 1'b0;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? mo[31-i] : 1'b0;
      wait_clk(8);
      mi = {mi[30:0], miso};
      oe_all = oe_all & miso_oe;
      oe_any = oe_any | miso_oe;
      sck = 1'b1;
      wait_clk(8);
      sck = 1'b0;
    end
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(1);
    oe_after = miso_oe;
    wait_clk(12);
  endtask

  task automatic model_update(input logic [31:0] cmd);
    logic [9:0] ta;
    ta = cmd[31:22];
    if (ref_crc(cmd[31:3]) != cmd[2:0]) begin
      e_drive = 1'b0; e_tag = "R3";
    end else if (ta[9:8] != cfg_addr) begin
      e_drive = 1'b0; e_tag = "R4";
    end else if (ta[7]) begin
      e_drive = 1'b1; e_sens = 1'b1; e_sa = ta[7:0]; e_stat = sns_stat;
      e_data = {sns_data, 4'h0}; e_tag = "R1 R5 R6 R9";
    end else if (ta[6:0] == ID_REG) begin
      e_drive = 1'b1; e_sens = 1'b0; e_sa = ta[7:0]; e_stat = 2'b00;
      e_data = DEV_ID; e_tag = "R7 R9";
    end else begin
      e_drive = 1'b0; e_tag = "R8";
    end
  endtask

  task automatic run_cmd(input logic [31:0] cmd);
    logic [31:0] mi;
    logic        all_oe, any_oe, after_oe;
    logic [31:0] ew;
    ew = exp_word(cfg_addr);
    xfer(cmd, 32, mi, all_oe, any_oe, after_oe);
    if (e_drive) chk(all_oe && (mi == ew), e_tag, mi, ew);
    else         chk(!any_oe && (mi == 32'h0), e_tag, {mi[31:1], any_oe}, 32'h0);
    model_update(cmd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] mi;
    logic        all_oe, any_oe, after_oe;
    logic [31:0] ew;

    e_drive = 1'b1; e_sens = 1'b0; e_sa = 8'h00; e_stat = 2'b01; e_data = 16'h0;
    e_tag = "R10";

    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    // R2: idle bus after reset
    chk(!miso_oe && !miso, "R2", {30'b0, miso_oe, miso}, 32'h0);

    // vector table: each frame checks the reply to the previous command
    for (int k = 0; k < NVEC; k++) begin
      cfg_addr = VEC[k][26:25];
      sns_stat = VEC[k][24:23];
      sns_data = VEC[k][22:11];
      run_cmd(make_cmd(VEC[k][10:1], VEC[k][0]));
    end

    // literal command words: good CRC sensor read to slave 3, then corrupted
    cfg_addr = 2'd3; sns_stat = 2'b11; sns_data = 12'h5A5;
    run_cmd(32'hFFFF_FFF8);
    run_cmd(32'hFFFF_FFFF);
    cfg_addr = 2'd0;
    run_cmd(32'h0FF2_C8FE);

    // R11: short and long frames are discarded
    sns_stat = 2'b00; sns_data = 12'h3C5;
    run_cmd(make_cmd(10'h0C1, 1'b0));
    ew = exp_word(cfg_addr);
    xfer(make_cmd(10'h02A, 1'b0), 10, mi, all_oe, any_oe, after_oe);
    chk(all_oe && (mi[9:0] == ew[31:22]), "R11", {22'b0, mi[9:0]}, {22'b0, ew[31:22]});
    // R2: enable drops one clock after CS rises
    chk(!after_oe, "R2", {31'b0, after_oe}, 32'h0);
    sns_data = 12'h111;
    xfer(make_cmd(10'h005, 1'b0), 33, mi, all_oe, any_oe, after_oe);
    chk(all_oe, "R11", {31'b0, all_oe}, 32'h1);
    e_tag = "R11";
    run_cmd(make_cmd(10'h02A, 1'b0));
    run_cmd(make_cmd(10'h0FF, 1'b0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule